// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This block computes signed and unsigned products and quotients for an integer datapath. It works at two operand sizes. In byte size it forms a 16-bit product from two 8-bit operands, or splits a 16-bit dividend by an 8-bit divisor. In word size it forms a 32-bit product from two 16-bit operands, or splits a 32-bit dividend by a 16-bit divisor. A division returns a single packed value: the quotient sits in the low half of the destination and the remainder in the high half.

The surrounding datapath presents the current destination register value and the source register value, together with the size, signedness and operation selects. It then pulses `start` for one cycle. The unit captures everything it needs at that edge and works one bit per cycle on operand magnitudes. When it finishes it presents the new destination value with a one-cycle `done` strobe. Signed operations also report N and Z through a flag write strobe. A zero divisor is caught when the operation is accepted. In that case the destination value comes back unchanged, the flag update shows Z set, and `div_zero` is raised.

Top module: `muldiv_unit`

## Requirements
- R1: Byte multiply (`op_div`=0, `size_word`=0) multiplies `dst_in[7:0]` by `src_in[7:0]`. It returns the 16-bit product in `result[15:0]` and passes `dst_in[31:16]` through to `result[31:16]`. `dst_in[15:8]` and `src_in[15:8]` do not affect the result.
- R2: Word multiply (`op_div`=0, `size_word`=1) multiplies `dst_in[15:0]` by `src_in[15:0]` and returns the full 32-bit product in `result`.
- R3: With `is_signed`=1 both operands are taken as two's complement at the selected size. With `is_signed`=0 they are taken as unsigned.
- R4: Byte divide (`op_div`=1, `size_word`=0) divides `dst_in[15:0]` by `src_in[7:0]`. The quotient goes to `result[7:0]`, the remainder to `result[15:8]`, and `dst_in[31:16]` passes through to `result[31:16]`.
- R5: Word divide (`op_div`=1, `size_word`=1) divides `dst_in[31:0]` by `src_in[15:0]`. The quotient goes to `result[15:0]` and the remainder to `result[31:16]`.
- R6: Signed divide rounds the quotient toward zero, and the remainder takes the sign of the dividend.
- R7: For signed operations `flag_we` is 1 in the `done` cycle. `flag_n` is then the top bit of the product (bit 15 for byte, bit 31 for word) or of the quotient field (bit 7 for byte, bit 15 for word). `flag_z` is 1 when that field is zero. For unsigned operations `flag_we` is 0.
- R8: A divide whose divisor field is zero completes one edge after it is accepted. It returns `dst_in` unchanged in `result` and raises `div_zero` for that one `done` cycle, with `flag_we`=1, `flag_z`=1 and `flag_n`=0.
- R9: `done` rises a fixed number of clock edges after the accepting edge: 9 for a byte multiply, 17 for a word multiply, 17 for a byte divide and 33 for a word divide. It stays high for exactly one cycle. `busy` is high from the accepting edge until the `done` cycle.
- R10: A `start` pulse while `busy` is high is ignored. The running operation finishes at its own time with its own result, and no extra `done` follows.
- R11: After reset `done`, `busy`, `div_zero` and `flag_we` are 0, and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when not busy) |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| size_word | input | 1 | 0 = byte size, 1 = word size |
| is_signed | input | 1 | 1 = two's complement operands |
| dst_in | input | 32 | Current destination register value |
| src_in | input | 16 | Source register value |
| result | output | 32 | New destination value, valid with done |
| flag_n | output | 1 | Negative flag, valid when flag_we |
| flag_z | output | 1 | Zero flag, valid when flag_we |
| flag_we | output | 1 | Flags should be written this cycle |
| div_zero | output | 1 | Divide by zero seen, one cycle with done |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Operation in progress |

## Verification
Each operation is exercised at both sizes with several operand patterns. All-ones unsigned operands separate zero extension from sign extension, since the same bit patterns give -1 times -1 when signed. Mixed-sign pairs with the most negative byte value show whether the product sign and magnitude are restored correctly. Dividend/divisor sign combinations for division tell truncation toward zero apart from floor rounding, and show whether the remainder takes the dividend's sign. Non-zero upper bytes in the unused source and destination fields catch a wrong field select. Zero divisors whose upper source byte is non-zero separate a field-based zero test from a whole-word test. A second `start` issued mid-operation separates true lockout from a restart.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int unsigned MD_HALF_W = 8;
    localparam int unsigned MD_OP_W   = 2 * MD_HALF_W;
    localparam int unsigned MD_DST_W  = 4 * MD_HALF_W;
    localparam int unsigned MD_CNT_W  = $clog2(MD_DST_W + 1);

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_RUN  = 2'd1,
        MD_FIN  = 2'd2
    } md_state_e;

    // Per-operation context held for the packing stage
    typedef struct packed {
        logic                is_div;
        logic                wide;
        logic                sgn;
        logic                dz;
        logic                neg_main;   // product or quotient must be negated
        logic                neg_rem;    // remainder must be negated
        logic [MD_DST_W-1:0] dst_keep;
    } md_job_t;

    // Magnitudes and iteration count handed to the engine
    typedef struct packed {
        logic [MD_DST_W-1:0] num;
        logic [MD_OP_W-1:0]  den;
        logic [MD_CNT_W-1:0] steps;
    } md_opnd_t;

    function automatic logic [MD_OP_W-1:0] md_neg_op(input logic [MD_OP_W-1:0] v,
                                                     input logic en);
        return en ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [MD_DST_W-1:0] md_neg_dst(input logic [MD_DST_W-1:0] v,
                                                       input logic en);
        return en ? (~v + 1'b1) : v;
    endfunction

    function automatic logic [MD_CNT_W-1:0] md_step_count(input logic is_div,
                                                          input logic wide,
                                                          input logic dz);
        logic [MD_CNT_W-1:0] n;
        if (dz)
            n = '0;
        else if (is_div)
            n = wide ? MD_CNT_W'(MD_DST_W) : MD_CNT_W'(MD_OP_W);
        else
            n = wide ? MD_CNT_W'(MD_OP_W) : MD_CNT_W'(MD_HALF_W);
        return n;
    endfunction

endpackage

// File: rtl/md_operand_prep.sv
module md_operand_prep
    import muldiv_pkg::*;
(
    input  logic                op_div,
    input  logic                size_word,
    input  logic                is_signed,
    input  logic [MD_DST_W-1:0] dst_in,
    input  logic [MD_OP_W-1:0]  src_in,
    output md_job_t             job,
    output md_opnd_t            opnd
);

    logic [MD_OP_W-1:0]  a_ext, b_ext, a_mag, b_mag;
    logic [MD_DST_W-1:0] dv_ext, dv_mag;
    logic                sa, sb, sd, dz;

    always_comb begin
        // multiplicand and source operand at the selected size
        a_ext = size_word ? dst_in[MD_OP_W-1:0]
                          : {{MD_HALF_W{is_signed & dst_in[MD_HALF_W-1]}}, dst_in[MD_HALF_W-1:0]};
        b_ext = size_word ? src_in
                          : {{MD_HALF_W{is_signed & src_in[MD_HALF_W-1]}}, src_in[MD_HALF_W-1:0]};
        sa    = is_signed & a_ext[MD_OP_W-1];
        sb    = is_signed & b_ext[MD_OP_W-1];
        a_mag = md_neg_op(a_ext, sa);
        b_mag = md_neg_op(b_ext, sb);

        // dividend at the selected size
        dv_ext = size_word ? dst_in
                           : {{MD_OP_W{is_signed & dst_in[MD_OP_W-1]}}, dst_in[MD_OP_W-1:0]};
        sd     = is_signed & dv_ext[MD_DST_W-1];
        dv_mag = md_neg_dst(dv_ext, sd);

        dz = op_div & (b_ext == '0);

        job.is_div   = op_div;
        job.wide     = size_word;
        job.sgn      = is_signed;
        job.dz       = dz;
        job.neg_main = op_div ? (sd ^ sb) : (sa ^ sb);
        job.neg_rem  = sd;
        job.dst_keep = dst_in;

        if (op_div)
            opnd.num = size_word ? dv_mag : {dv_mag[MD_OP_W-1:0], {MD_OP_W{1'b0}}};
        else
            opnd.num = {{MD_OP_W{1'b0}}, a_mag};
        opnd.den   = b_mag;
        opnd.steps = md_step_count(op_div, size_word, dz);
    end

endmodule

// File: rtl/md_iter_core.sv
module md_iter_core
    import muldiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                is_div,
    input  md_opnd_t            opnd,
    output logic                busy,
    output logic                fin,
    output logic [MD_DST_W-1:0] prod_mag,
    output logic [MD_OP_W-1:0]  quo_mag,
    output logic [MD_OP_W-1:0]  rem_mag
);

    md_state_e           state_q;
    logic [MD_CNT_W-1:0] cnt_q;
    logic                div_q;
    logic [MD_DST_W-1:0] acc_q, mcand_q, q_q;
    logic [MD_OP_W-1:0]  mplier_q, r_q, den_q;

    // one restoring division step
    logic [MD_OP_W:0]    trial;
    logic                ge;
    logic [MD_OP_W-1:0]  r_next;

    always_comb begin
        trial  = {r_q, q_q[MD_DST_W-1]};
        ge     = trial >= {1'b0, den_q};
        r_next = ge ? MD_OP_W'(trial - {1'b0, den_q}) : trial[MD_OP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= MD_IDLE;
            cnt_q    <= '0;
            div_q    <= 1'b0;
            acc_q    <= '0;
            mcand_q  <= '0;
            q_q      <= '0;
            mplier_q <= '0;
            r_q      <= '0;
            den_q    <= '0;
        end else begin
            case (state_q)
                MD_IDLE: begin
                    if (load) begin
                        div_q    <= is_div;
                        cnt_q    <= opnd.steps;
                        acc_q    <= '0;
                        mcand_q  <= opnd.num;
                        mplier_q <= opnd.den;
                        q_q      <= opnd.num;
                        r_q      <= '0;
                        den_q    <= opnd.den;
                        state_q  <= (opnd.steps == '0) ? MD_FIN : MD_RUN;
                    end
                end
                MD_RUN: begin
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == MD_CNT_W'(1))
                        state_q <= MD_FIN;
                    if (div_q) begin
                        q_q <= {q_q[MD_DST_W-2:0], ge};
                        r_q <= r_next;
                    end else begin
                        if (mplier_q[0])
                            acc_q <= acc_q + mcand_q;
                        mcand_q  <= mcand_q << 1;
                        mplier_q <= mplier_q >> 1;
                    end
                end
                MD_FIN:  state_q <= MD_IDLE;
                default: state_q <= MD_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != MD_IDLE);
    assign fin      = (state_q == MD_FIN);
    assign prod_mag = acc_q;
    assign quo_mag  = q_q[MD_OP_W-1:0];
    assign rem_mag  = r_q;

endmodule

// File: rtl/md_result_pack.sv
module md_result_pack
    import muldiv_pkg::*;
(
    input  md_job_t             job,
    input  logic [MD_DST_W-1:0] prod_mag,
    input  logic [MD_OP_W-1:0]  quo_mag,
    input  logic [MD_OP_W-1:0]  rem_mag,
    output logic [MD_DST_W-1:0] packed_res,
    output logic                fn,
    output logic                fz,
    output logic                fwe
);

    logic [MD_DST_W-1:0] prod_s;
    logic [MD_OP_W-1:0]  quo_s, rem_s;

    always_comb begin
        prod_s = md_neg_dst(prod_mag, job.neg_main);
        quo_s  = md_neg_op(quo_mag, job.neg_main);
        rem_s  = md_neg_op(rem_mag, job.neg_rem);
        fwe    = job.sgn;

        if (job.dz) begin
            packed_res = job.dst_keep;
            fwe        = 1'b1;
            fn         = 1'b0;
            fz         = 1'b1;
        end else if (!job.is_div) begin
            if (job.wide) begin
                packed_res = prod_s;
                fn         = prod_s[MD_DST_W-1];
                fz         = (prod_s == '0);
            end else begin
                packed_res = {job.dst_keep[MD_DST_W-1:MD_OP_W], prod_s[MD_OP_W-1:0]};
                fn         = prod_s[MD_OP_W-1];
                fz         = (prod_s[MD_OP_W-1:0] == '0);
            end
        end else begin
            if (job.wide) begin
                packed_res = {rem_s, quo_s};
                fn         = quo_s[MD_OP_W-1];
                fz         = (quo_s == '0);
            end else begin
                packed_res = {job.dst_keep[MD_DST_W-1:MD_OP_W],
                              rem_s[MD_HALF_W-1:0], quo_s[MD_HALF_W-1:0]};
                fn         = quo_s[MD_HALF_W-1];
                fz         = (quo_s[MD_HALF_W-1:0] == '0);
            end
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                op_div,
    input  logic                size_word,
    input  logic                is_signed,
    input  logic [MD_DST_W-1:0] dst_in,
    input  logic [MD_OP_W-1:0]  src_in,
    output logic [MD_DST_W-1:0] result,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_we,
    output logic                div_zero,
    output logic                done,
    output logic                busy
);

    md_job_t             job_d, job_q;
    md_opnd_t            opnd_d;
    logic                accept, core_busy, core_fin;
    logic [MD_DST_W-1:0] prod_mag, packed_res;
    logic [MD_OP_W-1:0]  quo_mag, rem_mag;
    logic                fn, fz, fwe;

    assign accept = start & ~core_busy;

    md_operand_prep u_prep (
        .op_div    (op_div),
        .size_word (size_word),
        .is_signed (is_signed),
        .dst_in    (dst_in),
        .src_in    (src_in),
        .job       (job_d),
        .opnd      (opnd_d)
    );

    md_iter_core u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .is_div   (op_div),
        .opnd     (opnd_d),
        .busy     (core_busy),
        .fin      (core_fin),
        .prod_mag (prod_mag),
        .quo_mag  (quo_mag),
        .rem_mag  (rem_mag)
    );

    md_result_pack u_pack (
        .job        (job_q),
        .prod_mag   (prod_mag),
        .quo_mag    (quo_mag),
        .rem_mag    (rem_mag),
        .packed_res (packed_res),
        .fn         (fn),
        .fz         (fz),
        .fwe        (fwe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q    <= '0;
            result   <= '0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_we  <= 1'b0;
            div_zero <= 1'b0;
            done     <= 1'b0;
        end else begin
            if (accept)
                job_q <= job_d;
            done     <= core_fin;
            div_zero <= core_fin & job_q.dz;
            flag_we  <= core_fin & fwe;
            if (core_fin) begin
                result <= packed_res;
                flag_n <= fn;
                flag_z <= fz;
            end
        end
    end

    assign busy = core_busy;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
    import muldiv_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                op_div,
    input logic                size_word,
    input logic                is_signed,
    input logic [MD_DST_W-1:0] dst_in,
    input logic [MD_OP_W-1:0]  src_in,
    input logic [MD_DST_W-1:0] result,
    input logic                flag_n,
    input logic                flag_z,
    input logic                flag_we,
    input logic                div_zero,
    input logic                done,
    input logic                busy
);

    // shadow of the accepted request, kept from the ports alone
    logic [MD_DST_W-1:0] c_dst;
    logic                c_div, c_wide, c_sgn, c_dz;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_dst  <= '0;
            c_div  <= 1'b0;
            c_wide <= 1'b0;
            c_sgn  <= 1'b0;
            c_dz   <= 1'b0;
        end else if (start && !busy) begin
            c_dst  <= dst_in;
            c_div  <= op_div;
            c_wide <= size_word;
            c_sgn  <= is_signed;
            c_dz   <= op_div && (size_word ? (src_in == '0)
                                           : (src_in[MD_HALF_W-1:0] == '0));
        end
    end

    assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_dz_keeps_dst_R8: assert property (@(posedge clk) disable iff (rst)
        (done && c_dz) |-> (result == c_dst && div_zero && flag_we && flag_z && !flag_n));

    assert_dz_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> (done && c_div));

    assert_unsigned_no_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !c_sgn && !c_dz) |-> !flag_we);

    assert_mul_sign_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !c_div && c_sgn) |->
            (flag_n == (c_wide ? result[MD_DST_W-1] : result[MD_OP_W-1])));

    assert_byte_upper_kept_R1: assert property (@(posedge clk) disable iff (rst)
        (done && !c_wide) |-> (result[MD_DST_W-1:MD_OP_W] == c_dst[MD_DST_W-1:MD_OP_W]));

endmodule

bind muldiv_unit muldiv_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op_div    (op_div),
    .size_word (size_word),
    .is_signed (is_signed),
    .dst_in    (dst_in),
    .src_in    (src_in),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_we   (flag_we),
    .div_zero  (div_zero),
    .done      (done),
    .busy      (busy)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic        size_word = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dst_in = '0;
    logic [15:0] src_in = '0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_we, div_zero, done, busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    muldiv_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_div    (op_div),
        .size_word (size_word),
        .is_signed (is_signed),
        .dst_in    (dst_in),
        .src_in    (src_in),
        .result    (result),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_we   (flag_we),
        .div_zero  (div_zero),
        .done      (done),
        .busy      (busy)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        is_div;
        logic        wide;
        logic        sgn;
        logic [31:0] dst;
        logic [15:0] src;
        logic [31:0] exp;
        logic        we;
        logic        n;
        logic        z;
        logic        dz;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b0, 1'b0, 1'b0, 32'hAAAA12FF, 16'h34FF, 32'hAAAAFE01, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 255*255
        '{4'd3, 1'b0, 1'b0, 1'b1, 32'hAAAA12FF, 16'h34FF, 32'hAAAA0001, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 -1*-1
        '{4'd3, 1'b0, 1'b0, 1'b1, 32'h00007F80, 16'h007F, 32'h0000C080, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 -128*127
        '{4'd2, 1'b0, 1'b1, 1'b0, 32'h1234FFFF, 16'hFFFF, 32'hFFFE0001, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
        '{4'd2, 1'b0, 1'b1, 1'b1, 32'h5555FFFF, 16'h0002, 32'hFFFFFFFE, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 -1*2
        '{4'd7, 1'b0, 1'b1, 1'b1, 32'h77770000, 16'h8000, 32'h00000000, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 zero
        '{4'd4, 1'b1, 1'b0, 1'b0, 32'hBEEF0064, 16'hAB07, 32'hBEEF020E, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 100/7
        '{4'd6, 1'b1, 1'b0, 1'b1, 32'h0000FF9C, 16'h0007, 32'h0000FEF2, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 -100/7
        '{4'd6, 1'b1, 1'b0, 1'b1, 32'h00000064, 16'h00F9, 32'h000002F2, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 100/-7
        '{4'd5, 1'b1, 1'b1, 1'b0, 32'h000F4240, 16'h03E8, 32'h000003E8, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
        '{4'd6, 1'b1, 1'b1, 1'b1, 32'hFFF0BDBF, 16'h03E8, 32'hFFFFFC18, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
        '{4'd7, 1'b1, 1'b1, 1'b1, 32'h00000005, 16'h000A, 32'h00050000, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 q=0
        '{4'd4, 1'b1, 1'b0, 1'b0, 32'h11110003, 16'h00C8, 32'h11110300, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 3/200
        '{4'd6, 1'b1, 1'b1, 1'b1, 32'hFFFFFFF9, 16'h0002, 32'hFFFFFFFD, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 -7/2
        '{4'd8, 1'b1, 1'b0, 1'b1, 32'hCAFE1234, 16'hFF00, 32'hCAFE1234, 1'b1, 1'b0, 1'b1, 1'b1}, // R8 byte
        '{4'd8, 1'b1, 1'b1, 1'b0, 32'h87654321, 16'h0000, 32'h87654321, 1'b1, 1'b0, 1'b1, 1'b1}  // R8 word
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int exp_lat(input vec_t v);
        if (v.dz) return 1;
        if (v.is_div) return v.wide ? 33 : 17;
        return v.wide ? 17 : 9;
    endfunction

    // issue one operation, return edges from the accepting edge until done
    task automatic run_op(input logic d, input logic w, input logic s,
                          input logic [31:0] dv, input logic [15:0] sv, output int lat);
        @(negedge clk);
        op_div = d; size_word = w; is_signed = s; dst_in = dv; src_in = sv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        int lat;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check(!done && !busy && !div_zero && !flag_we, "R11",
              {28'd0, done, busy, div_zero, flag_we}, 32'd0);
        check(result == 32'd0, "R11", result, 32'd0);

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d", VECS[i].req);
            run_op(VECS[i].is_div, VECS[i].wide, VECS[i].sgn, VECS[i].dst, VECS[i].src, lat);
            check(result == VECS[i].exp, tag, result, VECS[i].exp);
            check(div_zero == VECS[i].dz, "R8", {31'd0, div_zero}, {31'd0, VECS[i].dz});
            check(flag_we == VECS[i].we, "R7", {31'd0, flag_we}, {31'd0, VECS[i].we});
            if (VECS[i].we)
                check({flag_n, flag_z} == {VECS[i].n, VECS[i].z}, "R7",
                      {30'd0, flag_n, flag_z}, {30'd0, VECS[i].n, VECS[i].z});
            check(lat == exp_lat(VECS[i]), "R9", lat, exp_lat(VECS[i]));
            @(negedge clk);
            check(!done && !div_zero, "R9", {30'd0, done, div_zero}, 32'd0);
        end

        // R9 busy high during a run
        @(negedge clk);
        op_div = 1'b0; size_word = 1'b0; is_signed = 1'b0;
        dst_in = 32'h00000003; src_in = 16'h0004;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R9", {31'd0, busy}, 32'd1);
        while (!done) @(negedge clk);
        check(result == 32'h0000000C, "R1", result, 32'h0000000C);

        // R10 start while busy ignored
        @(negedge clk);
        op_div = 1'b0; size_word = 1'b1; is_signed = 1'b0;
        dst_in = 32'h00020003; src_in = 16'h0005;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (3) begin @(negedge clk); lat++; end
        op_div = 1'b1; size_word = 1'b0; is_signed = 1'b1;
        dst_in = 32'hFFFF0000; src_in = 16'h0000;
        start = 1'b1;
        @(negedge clk);
        lat++;
        start = 1'b0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        check(lat == 17, "R10", lat, 17);
        check(result == 32'h0000000F, "R10", result, 32'h0000000F);
        check(!flag_we && !div_zero, "R10", {30'd0, flag_we, div_zero}, 32'd0);
        lat = 0;
        repeat (40) begin
            @(negedge clk);
            if (done) lat++;
        end
        check(lat == 0, "R10", lat, 0);
        check(result == 32'h0000000F, "R10", result, 32'h0000000F);

        finish_run();
    end

endmodule